// File: doc/BRIEF.md
# Go-Back-N Sender Controller

This block runs the transmit side of a sliding-window retransmission protocol. It numbers outgoing packets with a sequence number that wraps, and it never lets more than a window's worth of packets be in flight without acknowledgement. When the far end reports a loss, or when a retransmission timer runs out, it rewinds to the oldest unacknowledged packet and sends everything outstanding again, in order.

The packet payloads live in an external buffer addressed by sequence number. The controller asks that buffer for the packet it wants to send next. The buffer grants the request when it can deliver that packet, and the controller then issues a one-cycle send strobe carrying the number. Acknowledgements arrive on a single-cycle input that carries a type (positive or negative) and a sequence number. Both types are cumulative.

Top module: `gbn_sender`

## Requirements
- R1: Out of reset nothing is outstanding and no strobe is given. `rd_req` is 1, `rd_seq` is 0 and `tx_send` is 0.
- R2: Fresh packets take consecutive sequence numbers modulo 2^SEQ_W, starting at 0. Each goes out once with `tx_retx` = 0.
- R3: At most WIN packets are unacknowledged. With WIN outstanding and nothing to resend, `rd_req` stays low.
- R4: A positive acknowledgement (`ack_neg` = 0) for a number n inside the outstanding range moves the window base to n+1. This frees that many slots for fresh packets.
- R5: A negative acknowledgement (`ack_neg` = 1) for an in-range n moves the base to n+1. The controller then requests n+1 in the next cycle and resends every outstanding packet in order with `tx_retx` = 1, before any fresh packet.
- R6: An acknowledgement whose number is outside the outstanding range [base, next fresh number − 1] is ignored. This includes any acknowledgement that arrives while nothing is outstanding.
- R7: When TMO_CYC edges pass after the last timer restart without a restart, the controller rewinds to the base. The first resend strobe appears TMO_CYC+1 edges after the restart edge.
- R8: The timer restarts when the base advances or when a rewind begins. It neither runs nor expires while nothing is outstanding.
- R9: If an in-range acknowledgement arrives in the same cycle the timer expires, the acknowledgement is acted on and the expiry is dropped.
- R10: A positive acknowledgement that arrives during a resend lifts the resend point to the new base. Packets it covers are skipped.
- R11: `tx_send` pulses exactly one cycle after each granted request (`rd_req` and `rd_gnt` both 1), and `tx_seq` equals the `rd_seq` that was granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req | output | 1 | Request for the packet at `rd_seq` |
| rd_seq | output | SEQ_W | Sequence number requested from the packet buffer |
| rd_gnt | input | 1 | Buffer accepts the request this cycle |
| tx_send | output | 1 | One-cycle send strobe |
| tx_seq | output | SEQ_W | Sequence number being sent |
| tx_retx | output | 1 | 1 when the strobe is a resend |
| ack_valid | input | 1 | Acknowledgement present this cycle |
| ack_neg | input | 1 | 0 = positive, 1 = negative acknowledgement |
| ack_num | input | SEQ_W | Cumulative acknowledgement number |

## Verification
The bench builds the block with SEQ_W = 3, WIN = 4 and TMO_CYC = 24. A 24-cycle timeout lets several expiries, and an acknowledgement placed exactly on an expiry edge, happen within a short run. Eight sequence numbers with a window of four means the run wraps past 7 to 0 and lands acknowledgements on both sides of the outstanding range, including stale and far-ahead numbers. Strobe cycles are compared against exact edge counts measured from the acknowledgement or restart that caused them.

// File: rtl/gbn_pkg.sv
// Shared types for the Go-Back-N sender.
// Assumes: nothing; holds only the window event encoding.
package gbn_pkg;

    // What the window does at the next edge, after acknowledgement and
    // timer arbitration.
    typedef enum logic [1:0] {
        EV_IDLE   = 2'd0,  // no change to base or resend point
        EV_SLIDE  = 2'd1,  // positive acknowledgement in range
        EV_REJECT = 2'd2,  // negative acknowledgement in range
        EV_EXPIRE = 2'd3   // retransmission timer ran out
    } win_evt_e;

endpackage

// File: rtl/gbn_ack_filter.sv
// Acknowledgement filter and loss arbiter.
// Checks whether an incoming acknowledgement falls inside the outstanding
// range and turns it, or a timer expiry, into one window event plus the new
// base. An in-range acknowledgement takes precedence over an expiry.
// Assumes: 2**SEQ_W > WIN, so modulo offsets from base are unambiguous.
module gbn_ack_filter
    import gbn_pkg::*;
#(
    parameter int SEQ_W = 3,
    parameter int WIN   = 4
) (
    input  logic                       ack_valid,
    input  logic                       ack_neg,
    input  logic [SEQ_W-1:0]           ack_num,
    input  logic [SEQ_W-1:0]           base,
    input  logic [$clog2(WIN+1)-1:0]   out_cnt,
    input  logic                       tmo,
    output logic                       ack_hit,
    output win_evt_e                   evt,
    output logic [SEQ_W-1:0]           new_base
);

    localparam int CNT_W = $clog2(WIN + 1);
    localparam int DW    = (SEQ_W > CNT_W) ? SEQ_W : CNT_W;

    logic [SEQ_W-1:0] offs;

    // Distance of the acknowledged number above the window base.
    assign offs    = ack_num - base;
    assign ack_hit = ack_valid && (DW'(offs) < DW'(out_cnt));

    // Pick the event for this cycle; the acknowledgement wins over expiry.
    always_comb begin
        evt      = EV_IDLE;
        new_base = base;
        if (ack_hit) begin
            evt      = ack_neg ? EV_REJECT : EV_SLIDE;
            new_base = ack_num + 1'b1;
        end else if (tmo) begin
            evt = EV_EXPIRE;
        end
    end

endmodule

// File: rtl/gbn_window.sv
// Sliding-window pointer set.
// Holds the oldest unacknowledged number (base), the next fresh number and
// the resend point (cursor). The cursor equals the fresh number unless a
// rewind is in progress. Raises a request whenever there is something to
// resend or a free window slot.
// Assumes: 2**SEQ_W > WIN; new_base comes from the filter and lies within
// [base, next fresh number].
module gbn_window
    import gbn_pkg::*;
#(
    parameter int SEQ_W = 3,
    parameter int WIN   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  win_evt_e                   evt,
    input  logic [SEQ_W-1:0]           new_base,
    input  logic                       grant,
    output logic [SEQ_W-1:0]           base,
    output logic [SEQ_W-1:0]           cursor,
    output logic [$clog2(WIN+1)-1:0]   out_cnt,
    output logic                       resend_pend,
    output logic                       req,
    output logic                       busy_nxt
);

    localparam int CNT_W = $clog2(WIN + 1);
    localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN);

    logic [SEQ_W-1:0] fresh;
    logic [SEQ_W-1:0] cur_adv;
    logic [SEQ_W-1:0] cur_nxt;
    logic [SEQ_W-1:0] fresh_nxt;
    logic [SEQ_W-1:0] adv_offs;
    logic [SEQ_W-1:0] base_offs;

    // Occupancy and request generation from the current pointers.
    always_comb begin
        out_cnt     = CNT_W'(fresh - base);
        resend_pend = (cursor != fresh);
        req         = resend_pend || (out_cnt < WIN_C);
    end

    // Next-state pointers: grant advances, events rewind or lift the cursor.
    always_comb begin
        cur_adv   = grant ? cursor + 1'b1 : cursor;
        fresh_nxt = (grant && !resend_pend) ? fresh + 1'b1 : fresh;
        adv_offs  = cur_adv - base;
        base_offs = new_base - base;
        unique case (evt)
            EV_REJECT, EV_EXPIRE: cur_nxt = new_base;
            EV_SLIDE:             cur_nxt = (adv_offs < base_offs) ? new_base : cur_adv;
            default:              cur_nxt = cur_adv;
        endcase
        busy_nxt = (fresh_nxt != new_base);
    end

    // Pointer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base   <= '0;
            fresh  <= '0;
            cursor <= '0;
        end else begin
            base   <= new_base;
            fresh  <= fresh_nxt;
            cursor <= cur_nxt;
        end
    end

endmodule

// File: rtl/gbn_timer.sv
// Retransmission timer.
// Counts cycles while packets are outstanding and flags expiry after
// TMO_CYC cycles without a restart. Any window event restarts it; it is held
// at zero whenever the window will be empty.
// Assumes: TMO_CYC >= 2.
module gbn_timer
    import gbn_pkg::*;
#(
    parameter int TMO_CYC = 256
) (
    input  logic     clk,
    input  logic     rst_n,
    input  win_evt_e evt,
    input  logic     busy,
    input  logic     busy_nxt,
    output logic     tmo
);

    localparam int TW = $clog2(TMO_CYC);
    localparam logic [TW-1:0] LAST = TW'(TMO_CYC - 1);

    logic [TW-1:0] cnt;

    assign tmo = busy && (cnt == LAST);

    // Elapsed-cycle counter with restart and idle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if ((evt != EV_IDLE) || !busy_nxt) begin
            cnt <= '0;
        end else if (busy) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/gbn_sender.sv
// Go-Back-N sender controller, top level.
// Joins the acknowledgement filter, the window pointers and the timer,
// drives the request port toward the packet buffer, and registers a send
// strobe one cycle after every granted request.
// Assumes: the buffer grants only while rd_req is high and holds every
// outstanding packet until it is acknowledged.
module gbn_sender
    import gbn_pkg::*;
#(
    parameter int SEQ_W   = 3,
    parameter int WIN     = 4,
    parameter int TMO_CYC = 256
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic             rd_req,
    output logic [SEQ_W-1:0] rd_seq,
    input  logic             rd_gnt,
    output logic             tx_send,
    output logic [SEQ_W-1:0] tx_seq,
    output logic             tx_retx,
    input  logic             ack_valid,
    input  logic             ack_neg,
    input  logic [SEQ_W-1:0] ack_num
);

    localparam int CNT_W = $clog2(WIN + 1);

    win_evt_e         evt;
    logic [SEQ_W-1:0] new_base;
    logic [SEQ_W-1:0] base;
    logic [SEQ_W-1:0] cursor;
    logic [CNT_W-1:0] out_cnt;
    logic             resend_pend;
    logic             req;
    logic             busy_nxt;
    logic             ack_hit;
    logic             tmo;
    logic             grant;

    assign grant  = req && rd_gnt;
    assign rd_req = req;
    assign rd_seq = cursor;

    gbn_ack_filter #(.SEQ_W(SEQ_W), .WIN(WIN)) u_filter (
        .ack_valid (ack_valid),
        .ack_neg   (ack_neg),
        .ack_num   (ack_num),
        .base      (base),
        .out_cnt   (out_cnt),
        .tmo       (tmo),
        .ack_hit   (ack_hit),
        .evt       (evt),
        .new_base  (new_base)
    );

    gbn_window #(.SEQ_W(SEQ_W), .WIN(WIN)) u_window (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt         (evt),
        .new_base    (new_base),
        .grant       (grant),
        .base        (base),
        .cursor      (cursor),
        .out_cnt     (out_cnt),
        .resend_pend (resend_pend),
        .req         (req),
        .busy_nxt    (busy_nxt)
    );

    gbn_timer #(.TMO_CYC(TMO_CYC)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .evt      (evt),
        .busy     (out_cnt != '0),
        .busy_nxt (busy_nxt),
        .tmo      (tmo)
    );

    // Send strobe register: one pulse per grant, tagged fresh or resend.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_send <= 1'b0;
            tx_seq  <= '0;
            tx_retx <= 1'b0;
        end else begin
            tx_send <= grant;
            if (grant) begin
                tx_seq  <= cursor;
                tx_retx <= resend_pend;
            end
        end
    end

endmodule

// File: rtl/gbn_sender_chk.sv
// Protocol checker for gbn_sender, attached with bind.
// Observes ports plus the occupancy, filter hit, base and expiry signals.
module gbn_sender_chk #(
    parameter int SEQ_W = 3,
    parameter int WIN   = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     rd_req,
    input logic [SEQ_W-1:0]         rd_seq,
    input logic                     rd_gnt,
    input logic                     tx_send,
    input logic [SEQ_W-1:0]         tx_seq,
    input logic                     ack_valid,
    input logic                     ack_neg,
    input logic [SEQ_W-1:0]         ack_num,
    input logic [$clog2(WIN+1)-1:0] out_cnt,
    input logic                     ack_hit,
    input logic [SEQ_W-1:0]         base,
    input logic                     tmo
);

    localparam int CNT_W = $clog2(WIN + 1);
    localparam logic [CNT_W-1:0] WIN_C = CNT_W'(WIN);

    a_r3_window_limit: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= WIN_C);

    a_r11_strobe_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_gnt) |=> (tx_send && tx_seq == $past(rd_seq)));

    a_r11_quiet_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_req && rd_gnt) |=> !tx_send);

    a_r6_ignored_ack_keeps_base: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack_hit) |=> (base == $past(base)));

    a_r5_nack_rewinds: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && ack_neg && ack_hit) |=>
            (rd_req && rd_seq == SEQ_W'($past(ack_num) + 1'b1)));

    a_r8_no_expiry_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cnt == '0) |-> !tmo);

    a_r9_ack_beats_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo && ack_valid && ack_hit && !ack_neg) |=>
            (base == SEQ_W'($past(ack_num) + 1'b1)));

endmodule

bind gbn_sender gbn_sender_chk #(.SEQ_W(SEQ_W), .WIN(WIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_req    (rd_req),
    .rd_seq    (rd_seq),
    .rd_gnt    (rd_gnt),
    .tx_send   (tx_send),
    .tx_seq    (tx_seq),
    .ack_valid (ack_valid),
    .ack_neg   (ack_neg),
    .ack_num   (ack_num),
    .out_cnt   (out_cnt),
    .ack_hit   (ack_hit),
    .base      (base),
    .tmo       (tmo)
);

// File: tb/gbn_sender_tb_top.sv
`timescale 1ns/1ps
// Directed bench for gbn_sender: one task per scenario.
module gbn_sender_tb_top;

    localparam int SEQ_W = 3;
    localparam int WIN   = 4;
    localparam int TMO   = 24;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rd_req;
    logic [SEQ_W-1:0] rd_seq;
    logic             rd_gnt;
    logic             tx_send;
    logic [SEQ_W-1:0] tx_seq;
    logic             tx_retx;
    logic             ack_valid = 1'b0;
    logic             ack_neg = 1'b0;
    logic [SEQ_W-1:0] ack_num = '0;
    logic             gnt_en = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ack_edge = 0;

    int lg_seq [64];
    int lg_retx[64];
    int lg_cyc [64];
    int lg_n = 0;
    int mark = 0;

    always #5 clk = ~clk;

    assign rd_gnt = rd_req && gnt_en;

    gbn_sender #(.SEQ_W(SEQ_W), .WIN(WIN), .TMO_CYC(TMO)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .rd_req(rd_req), .rd_seq(rd_seq), .rd_gnt(rd_gnt),
        .tx_send(tx_send), .tx_seq(tx_seq), .tx_retx(tx_retx),
        .ack_valid(ack_valid), .ack_neg(ack_neg), .ack_num(ack_num)
    );

    // Edge counter: after edge E, cyc reads E at the following negedge.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Strobe logger, sampled between edges.
    always @(negedge clk) begin
        if (rst_n && tx_send && lg_n < 64) begin
            lg_seq[lg_n]  = int'(tx_seq);
            lg_retx[lg_n] = int'(tx_retx);
            lg_cyc[lg_n]  = cyc;
            lg_n          = lg_n + 1;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_tx(input string tag, input int idx, input int s, input int r);
        chk({tag, " seq"},  lg_seq[mark + idx],  s);
        chk({tag, " retx"}, lg_retx[mark + idx], r);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_now(input logic neg, input int num);
        @(negedge clk);
        ack_valid = 1'b1; ack_neg = neg; ack_num = SEQ_W'(num);
        @(negedge clk);
        ack_valid = 1'b0;
        ack_edge  = cyc;
    endtask

    task automatic ack_at(input int edge_no, input logic neg, input int num);
        @(negedge clk);
        while (cyc < edge_no - 1) @(negedge clk);
        ack_valid = 1'b1; ack_neg = neg; ack_num = SEQ_W'(num);
        @(negedge clk);
        ack_valid = 1'b0;
        ack_edge  = cyc;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 rd_req",  int'(rd_req), 1);
        chk("R1 rd_seq",  int'(rd_seq), 0);
        chk("R1 tx_send", int'(tx_send), 0);
    endtask

    task automatic t_fill();
        mark = lg_n;
        gnt_en = 1'b1;
        idle(8);
        chk("R3 fill count", lg_n - mark, 4);
        for (int i = 0; i < 4; i++) chk_tx("R2 fresh", i, i, 0);
        chk("R3 req low when full", int'(rd_req), 0);
    endtask

    task automatic t_slide();
        mark = lg_n;
        ack_now(1'b0, 1);
        idle(6);
        chk("R4 slide count", lg_n - mark, 2);
        chk_tx("R4 after slide", 0, 4, 0);
        chk_tx("R4 after slide", 1, 5, 0);
        chk("R3 req low again", int'(rd_req), 0);
    endtask

    task automatic t_ignore_range();
        mark = lg_n;
        ack_now(1'b0, 7);
        idle(6);
        ack_now(1'b1, 1);
        idle(6);
        chk("R6 no sends after stray acks", lg_n - mark, 0);
        chk("R6 req unchanged", int'(rd_req), 0);
    endtask

    task automatic t_reject_and_expire();
        int a;
        int b;
        mark = lg_n;
        ack_now(1'b1, 2);
        a = ack_edge;
        idle(TMO + 8);
        chk("R5+R7 log count", lg_n - mark, 8);
        chk_tx("R5 resend", 0, 3, 1);
        chk_tx("R5 resend", 1, 4, 1);
        chk_tx("R5 resend", 2, 5, 1);
        chk_tx("R5 fresh after resend", 3, 6, 0);
        chk("R5 resend starts next edge", lg_cyc[mark], a + 1);
        for (int i = 0; i < 4; i++) chk_tx("R7 timeout resend", 4 + i, 3 + i, 1);
        chk("R7 timeout strobe edge", lg_cyc[mark + 4], a + TMO + 1);
        b = a + TMO;
        // R9: positive ack exactly on the next expiry edge
        mark = lg_n;
        ack_at(b + TMO, 1'b0, 4);
        chk("R9 ack on expiry edge", ack_edge, b + TMO);
        idle(5);
        chk("R9 only fresh sends", lg_n - mark, 2);
        chk_tx("R9 fresh wrap", 0, 7, 0);
        chk_tx("R9 fresh wrap", 1, 0, 0);
        chk("R9 first fresh edge", lg_cyc[mark], b + TMO + 1);
        gnt_en = 1'b0;
    endtask

    task automatic t_idle_timer();
        mark = lg_n;
        ack_now(1'b0, 0);
        idle(3 * TMO);
        chk("R8 no expiry while empty", lg_n - mark, 0);
        chk("R8 req for fresh", int'(rd_req), 1);
        chk("R8 next fresh number", int'(rd_seq), 1);
        ack_now(1'b0, 5);
        mark = lg_n;
        gnt_en = 1'b1;
        idle(8);
        chk("R6 empty-window ack ignored", lg_n - mark, 4);
        for (int i = 0; i < 4; i++) chk_tx("R6 full window after stray", i, 1 + i, 0);
    endtask

    task automatic t_lift_cursor();
        gnt_en = 1'b0;
        ack_now(1'b1, 1);
        ack_now(1'b0, 3);
        mark = lg_n;
        gnt_en = 1'b1;
        idle(8);
        chk("R10 count", lg_n - mark, 4);
        chk_tx("R10 skip acked", 0, 4, 1);
        chk_tx("R10 fresh", 1, 5, 0);
        chk_tx("R10 fresh", 2, 6, 0);
        chk_tx("R10 fresh", 3, 7, 0);
        chk("R11 strobes back to back", lg_cyc[mark + 1] - lg_cyc[mark], 1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_fill();
        t_slide();
        t_ignore_range();
        t_reject_and_expire();
        t_idle_timer();
        t_lift_cursor();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule